// File: doc/BRIEF.md
# Pin-Interrupt GPIO Port

This block is a 32-pin general-purpose port that sits behind a simple synchronous register bus. Its output register can be written whole, or changed one bit at a time through three write-only views that set, clear or invert the bits written as one. Zero bits leave the output as it was, so independent agents never need a read-modify-write sequence. The pin levels are brought into the clock domain through a two-flop synchronizer, and the synchronized value can be read back.

Each pin carries a 4-bit interrupt mode that watches its synchronized level for a rising edge, a falling edge, either edge, a low level or a high level. A detection sets that pin's sticky status flag. Software clears a flag by writing a one to its bit in the status register. A single registered interrupt line is raised while any flag is set. Software typically reads the status word and then clears and services the set bits one at a time.

The bus has a valid strobe, a write strobe, a 9-bit byte address, 32-bit write data and registered read data. Address bit 8 selects one of two spaces. With bit 8 low, the data space is used. With bit 8 high, the port space is used, which holds the per-pin mode registers and the status register.

Top module: `pinport_irq`

## Requirements
- R1: After a synchronous reset, the output register, every mode field and every status flag are 0, and the interrupt output is low.
- R2: A write to data-space offset 0x00 loads the whole output register, which drives `pin_out` from the next cycle. A read of offset 0x00 returns the output register.
- R3: A write to data-space offset 0x04 forces to 1 each output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R4: A write to data-space offset 0x08 forces to 0 each output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R5: A write to data-space offset 0x0C inverts each output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R6: A read of data-space offset 0x10 returns the pin levels after a two-flop synchronizer. A read of 0x04, 0x08 or 0x0C returns 0.
- R7: Pin n has a mode register at address 0x100 + 4·n. Only bits 19:16 of that register are stored. A read returns those four bits in place, with every other bit 0.
- R8: Mode 0x9 sets a pin's flag on a 0→1 change of its synchronized level. Mode 0xA sets the flag on a 1→0 change. Mode 0xB sets the flag on either change.
- R9: Mode 0x8 sets a pin's flag on every cycle that the synchronized level is 0, and mode 0xC does so on every cycle that it is 1. Once the level no longer matches, the flag stays cleared after a clear.
- R10: Mode 0x0 and every code not listed in R8 or R9 never set a flag, whatever the pin does.
- R11: The status register is at address 0x1A0, with bit n for pin n. Writing 1 to a bit clears that flag and leaves every other flag as it was. Writing all ones clears every flag.
- R12: When a detection and a clear hit the same flag in the same cycle, the flag stays set.
- R13: The interrupt output is registered. In each cycle it equals the OR of all status flags from the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address; bit 8 selects the port space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output register |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The edge modes are tried with a rise and then a fall applied to three pins at once, one pin per edge mode, so that the flag pattern shows which mode reacts to which direction. The level modes are tried with a level held across a clear, which separates a sticky flag that a level re-sets at once from a flag that stays cleared after the level is gone. Two other patterns are also used. Pins in the disabled mode and in an unused mode are toggled, to show that they raise nothing. Two flags are set together and only one is cleared, to show that clearing one bit leaves the other alone. The output aliases are driven with mixed one and zero patterns over a known starting value, so that a bit that was wrongly touched shows up in the result.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] OFF_DOUT = 8'h00;
  localparam logic [7:0] OFF_SET  = 8'h04;
  localparam logic [7:0] OFF_CLR  = 8'h08;
  localparam logic [7:0] OFF_TGL  = 8'h0C;
  localparam logic [7:0] OFF_DIN  = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'hA0;
  localparam int         CFG_LSB  = 16;
  localparam int         CFG_W    = 4;

  typedef enum logic [3:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_BOTH = 4'hB,
    MODE_HIGH = 4'hC
  } pin_mode_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= raw;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/pp_pin_detect.sv
module pp_pin_detect
  import pp_pkg::*;
(
  input  logic [CFG_W-1:0] mode,
  input  logic             lvl,
  input  logic             lvl_prev,
  output logic             hit
);
  always_comb begin
    case (pin_mode_e'(mode))
      MODE_LOW:  hit = ~lvl;
      MODE_RISE: hit = lvl & ~lvl_prev;
      MODE_FALL: hit = ~lvl & lvl_prev;
      MODE_BOTH: hit = lvl ^ lvl_prev;
      MODE_HIGH: hit = lvl;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pp_flags.sv
module pp_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
      arm   <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | hit;
      irq   <= |flags;
      arm   <= 1'b1;
    end
  end

  // R12: a detection always lands, even against a clear
  assert_hit_sets_flag_R12: assert property (@(posedge clk) disable iff (rst || !arm)
    (|hit) |=> ((flags & $past(hit)) == $past(hit)));

  // R11: a flag not written with one is kept
  assert_flag_kept_R11: assert property (@(posedge clk) disable iff (rst || !arm)
    1'b1 |=> ((flags & ($past(flags) & ~$past(clr))) == ($past(flags) & ~$past(clr))));

  // R13: combined line follows the flags one cycle later
  assert_irq_follows_R13: assert property (@(posedge clk) disable iff (rst || !arm)
    1'b1 |=> (irq == (|$past(flags))));
endmodule

// File: rtl/pinport_irq.sv
module pinport_irq
  import pp_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 9,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic          irq
);
  localparam int OW       = AW - 1;
  localparam int IDXW     = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam int CTL_SPAN = NPIN * 4;

  logic            wr, rd, port_sel, ctl_hit;
  logic [OW-1:0]   off;
  logic [IDXW-1:0] idx;
  logic [NPIN-1:0] lvl, lvl_prev, hit, clr, flags;
  logic [CFG_W-1:0] cfg_q [NPIN];
  logic [DW-1:0]   rd_next;
  logic            arm;

  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign port_sel = bus_addr[AW-1];
  assign off      = bus_addr[OW-1:0];
  assign idx      = off[IDXW+1:2];
  assign ctl_hit  = port_sel && (32'(off) < 32'(CTL_SPAN)) && (off[1:0] == 2'b00);

  pp_sync #(.W(NPIN)) sync_i (
    .clk(clk), .rst(rst), .raw(pin_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g] <= '0;
      else if (wr && ctl_hit && idx == IDXW'(g))
        cfg_q[g] <= bus_wdata[CFG_LSB +: CFG_W];
    end

    pp_pin_detect det_i (
      .mode(cfg_q[g]), .lvl(lvl[g]), .lvl_prev(lvl_prev[g]), .hit(hit[g])
    );
  end

  assign clr = (wr && port_sel && off == OW'(OFF_STAT)) ? bus_wdata[NPIN-1:0] : '0;

  pp_flags #(.W(NPIN)) flags_i (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .flags(flags), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      arm     <= 1'b0;
    end else begin
      arm <= 1'b1;
      if (wr && !port_sel) begin
        case (off)
          OW'(OFF_DOUT): pin_out <= bus_wdata[NPIN-1:0];
          OW'(OFF_SET):  pin_out <= pin_out | bus_wdata[NPIN-1:0];
          OW'(OFF_CLR):  pin_out <= pin_out & ~bus_wdata[NPIN-1:0];
          OW'(OFF_TGL):  pin_out <= pin_out ^ bus_wdata[NPIN-1:0];
          default:       pin_out <= pin_out;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (!port_sel) begin
      if (off == OW'(OFF_DOUT))     rd_next[NPIN-1:0] = pin_out;
      else if (off == OW'(OFF_DIN)) rd_next[NPIN-1:0] = lvl;
    end else begin
      if (ctl_hit)                   rd_next[CFG_LSB +: CFG_W] = cfg_q[idx];
      else if (off == OW'(OFF_STAT)) rd_next[NPIN-1:0] = flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_next;
  end

  // R3: set view raises every written one
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst || !arm)
    (wr && !port_sel && off == OW'(OFF_SET)) |=>
      ((pin_out & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  // R4: clear view drops every written one
  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (rst || !arm)
    (wr && !port_sel && off == OW'(OFF_CLR)) |=>
      ((pin_out & $past(bus_wdata[NPIN-1:0])) == '0));

  // R5: toggle view inverts written ones only
  assert_tgl_alias_R5: assert property (@(posedge clk) disable iff (rst || !arm)
    (wr && !port_sel && off == OW'(OFF_TGL)) |=>
      (pin_out == ($past(pin_out) ^ $past(bus_wdata[NPIN-1:0]))));

  // R2: output register holds when no data-space write occurs
  assert_dout_hold_R2: assert property (@(posedge clk) disable iff (rst || !arm)
    !(wr && !port_sel) |=> $stable(pin_out));
endmodule

// File: tb/pinport_irq_tb_top.sv
module pinport_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_write;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  pinport_irq dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [8:0] ctl_addr(input int p);
    return 9'h100 + 9'(p * 4);
  endfunction

  task automatic set_mode(input int p, input logic [3:0] m);
    wr(ctl_addr(p), {12'h0, m, 16'h0});
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(9'h1A0, d); check("R1 status", d, 32'h0);
    rd(ctl_addr(9), d); check("R1 mode", d, 32'h0);
  endtask

  task automatic test_dout();
    logic [31:0] d;
    wr(9'h000, 32'hDEAD_BEEF);
    check("R2 pin_out", pin_out, 32'hDEAD_BEEF);
    rd(9'h000, d); check("R2 readback", d, 32'hDEAD_BEEF);
  endtask

  task automatic test_aliases();
    wr(9'h000, 32'hF0F0_00FF);
    wr(9'h004, 32'h0F00_0101);
    check("R3 set", pin_out, 32'hFFF0_01FF);
    wr(9'h008, 32'hF000_0003);
    check("R4 clear", pin_out, 32'h0FF0_01FC);
    wr(9'h00C, 32'h8001_00FF);
    check("R5 toggle", pin_out, 32'h8FF1_0103);
    wr(9'h00C, 32'h0);
    check("R5 toggle zero", pin_out, 32'h8FF1_0103);
  endtask

  task automatic test_input();
    logic [31:0] d;
    pin_in = 32'hA5A5_0F0F;
    settle(3);
    rd(9'h010, d); check("R6 input", d, 32'hA5A5_0F0F);
    rd(9'h004, d); check("R6 set view reads 0", d, 32'h0);
    rd(9'h00C, d); check("R6 toggle view reads 0", d, 32'h0);
    pin_in = 32'h0;
    settle(4);
  endtask

  task automatic test_ctrl();
    logic [31:0] d;
    wr(ctl_addr(31), 32'hFFFF_FFFF);
    rd(ctl_addr(31), d); check("R7 field only", d, 32'h000F_0000);
    rd(ctl_addr(30), d); check("R7 neighbour", d, 32'h0);
    set_mode(31, 4'h0);
  endtask

  task automatic test_edges();
    logic [31:0] d;
    set_mode(1, 4'h9); set_mode(2, 4'hA); set_mode(3, 4'hB);
    pin_in = 32'h0000_000E;
    settle(4);
    rd(9'h1A0, d); check("R8 rise pattern", d, 32'h0000_000A);
    check("R13 irq high", {31'h0, irq}, 32'h1);
    wr(9'h1A0, 32'hFFFF_FFFF);
    pin_in = 32'h0;
    settle(4);
    rd(9'h1A0, d); check("R8 fall pattern", d, 32'h0000_000C);
    set_mode(1, 4'h0); set_mode(2, 4'h0); set_mode(3, 4'h0);
    wr(9'h1A0, 32'hFFFF_FFFF);
  endtask

  task automatic test_level();
    logic [31:0] d;
    pin_in = 32'h0000_0020;
    settle(3);
    set_mode(5, 4'hC);
    settle(2);
    rd(9'h1A0, d); check("R9 high level", d, 32'h0000_0020);
    wr(9'h1A0, 32'h0000_0020);
    rd(9'h1A0, d); check("R12 clear loses to level", d, 32'h0000_0020);
    pin_in = 32'h0;
    settle(4);
    wr(9'h1A0, 32'h0000_0020);
    rd(9'h1A0, d); check("R9 level gone stays clear", d, 32'h0);
    set_mode(5, 4'h0);
    set_mode(6, 4'h8);
    settle(2);
    rd(9'h1A0, d); check("R9 low level", d, 32'h0000_0040);
    set_mode(6, 4'h0);
    wr(9'h1A0, 32'hFFFF_FFFF);
    rd(9'h1A0, d); check("R9 low cleared after off", d, 32'h0);
  endtask

  task automatic test_disabled();
    logic [31:0] d;
    set_mode(7, 4'h0); set_mode(8, 4'h5); set_mode(9, 4'hF);
    pin_in = 32'h0000_0380;
    settle(4);
    pin_in = 32'h0;
    settle(4);
    rd(9'h1A0, d); check("R10 no flags", d, 32'h0);
    check("R10 irq low", {31'h0, irq}, 32'h0);
    set_mode(8, 4'h0); set_mode(9, 4'h0);
  endtask

  task automatic test_w1c();
    logic [31:0] d;
    set_mode(1, 4'h9); set_mode(2, 4'h9);
    pin_in = 32'h0000_0006;
    settle(4);
    rd(9'h1A0, d); check("R11 both set", d, 32'h0000_0006);
    wr(9'h1A0, 32'h0000_0002);
    rd(9'h1A0, d); check("R11 one cleared", d, 32'h0000_0004);
    check("R13 irq still high", {31'h0, irq}, 32'h1);
    wr(9'h1A0, 32'hFFFF_FFFF);
    settle(1);
    check("R13 irq low", {31'h0, irq}, 32'h0);
    rd(9'h1A0, d); check("R11 all cleared", d, 32'h0);
    set_mode(1, 4'h0); set_mode(2, 4'h0);
    pin_in = 32'h0;
    settle(4);
  endtask

  initial begin
    rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    settle(4);
    rst = 1'b0;
    settle(1);
    test_reset();
    test_dout();
    test_aliases();
    test_input();
    test_ctrl();
    test_edges();
    test_level();
    test_disabled();
    test_w1c();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule